// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Updater

This unit sits in the address stage of a load/store pipeline. Each strobed request carries a mode code, a base address, a pointer word and a 10-bit signed offset field. From these it produces the effective address for the access, the value to write back to an address register, and a flag that says whether that write-back takes place. Three linear modes cover the cases of a fixed displacement, a pointer that is stepped before use, and a pointer that is stepped after use.

Two further modes serve buffer-oriented code. In these modes the pointer word is split into two halves. The low half is an index. The high half is either the length of a ring buffer or the step of a bit-reversed walk, as used in FFT data reordering. The access goes to base plus index. Only the index half of the pointer word is rewritten, and the upper half comes back unchanged. All outputs are registered and appear one clock after the input strobe, together with a valid flag.

Top module: `addr_step_unit`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `out_valid`, `wb_en`, `ea` and `wb_val` are all zero.
- R2: A request sampled with `in_valid` high at a rising edge shows its results on the outputs after that edge, with `out_valid` high. A rising edge with `in_valid` low drives `out_valid` and `wb_en` low.
- R3: The 10-bit `ofs` field is a two's complement value and is sign-extended to 32 bits before any addition; for example 10'h3FC means -4.
- R4: With mode 0 (displacement), `ea` = base + offset, `wb_val` carries the same sum and `wb_en` is low.
- R5: With mode 1 (step before use), `ea` = base + offset, `wb_val` = base + offset and `wb_en` is high.
- R6: With mode 2 (step after use), `ea` = base unchanged, `wb_val` = base + offset and `wb_en` is high.
- R7: With mode 3 (ring buffer), the pointer word's bits 15:0 are the index and bits 31:16 are the length. `ea` = base + index (zero-extended), `wb_en` is high and `wb_val[31:16]` equals the length. For a non-negative sum index + offset, the new index is that sum modulo the length.
- R8: In mode 3, a length of zero leaves the index unchanged in `wb_val`.
- R9: In mode 3, a negative sum index + offset has the length added once, and the result is truncated to 16 bits.
- R10: With mode 4 (bit-reversed walk), bits 31:16 of the pointer word are the step. `ea` = base + index, `wb_en` is high and `wb_val[31:16]` equals the step. The new index is mirror(mirror(index) + mirror(step)), where mirror swaps bit i with bit 15-i. Any carry out of bit 15 of the inner sum is dropped. The offset field has no effect in this mode.
- R11: Mode codes 5, 6 and 7 behave exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing mode code (0 to 4 defined) |
| base | input | 32 | Base address |
| ptr | input | 32 | Pointer word: index in [15:0], length or step in [31:16] |
| ofs | input | 10 | Signed offset field |
| out_valid | output | 1 | Registered results are valid |
| ea | output | 32 | Effective address |
| wb_val | output | 32 | Value for the address register write-back |
| wb_en | output | 1 | Write-back takes place |

## Verification
The ring-buffer cases cover a sum that lands exactly on the length, a large positive offset, a negative sum and a zero length. A design that wrapped one element early would fail on these, as would one that subtracted instead of adding on underflow or divided by zero. The bit-reversed cases step through the first few entries of a reversed sequence and include an all-ones index whose inner sum carries out of bit 15. A design that kept that carry, or that mirrored the wrong operand, would return a wrong index. Negative offsets in the linear modes catch a zero-extended offset field, and the step-after-use case catches an effective address that already includes the step. Mode codes 5 to 7, strobe gaps and a reset in the middle of a run check that `wb_en` never rises when it should not.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;

   typedef enum logic [2:0] {
      AM_DISP = 3'd0,
      AM_PRE  = 3'd1,
      AM_POST = 3'd2,
      AM_RING = 3'd3,
      AM_BREV = 3'd4
   } amode_e;

endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
   parameter int W = 16
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (W < 1) begin : g_bad_w
      $error("bit_mirror: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_swap
      assign dout[i] = din[W-1-i];
   end
endmodule

// File: rtl/brev_stepper.sv
module brev_stepper #(
   parameter int IW = 16
) (
   input  logic [IW-1:0] idx,
   input  logic [IW-1:0] step,
   output logic [IW-1:0] idx_next
);
   logic [IW-1:0] idx_m;
   logic [IW-1:0] step_m;
   logic [IW-1:0] sum_m;

   bit_mirror #(.W(IW)) i_mir_idx  (.din(idx),   .dout(idx_m));
   bit_mirror #(.W(IW)) i_mir_step (.din(step),  .dout(step_m));

   // carry out of the top bit is discarded by the width of sum_m
   assign sum_m = idx_m + step_m;

   bit_mirror #(.W(IW)) i_mir_sum  (.din(sum_m), .dout(idx_next));
endmodule

// File: rtl/ring_stepper.sv
module ring_stepper #(
   parameter int IW   = 16,
   parameter int OFSW = 10
) (
   input  logic [IW-1:0]   idx,
   input  logic [IW-1:0]   len,
   input  logic [OFSW-1:0] ofs,
   output logic [IW-1:0]   idx_next
);
   localparam int SW = IW + 2;

   if (OFSW > IW) begin : g_bad_ofsw
      $error("ring_stepper: OFSW must not exceed IW");
   end

   logic signed [SW-1:0] sum;
   logic signed [SW-1:0] ofs_x;
   logic        [SW-1:0] under;
   logic        [IW:0]   pos;
   logic        [IW:0]   divisor;
   logic        [IW:0]   rem;

   assign ofs_x   = SW'($signed(ofs));
   assign sum     = $signed({2'b00, idx}) + ofs_x;
   assign under   = sum + $signed({2'b00, len});
   assign pos     = sum[IW:0];
   assign divisor = (len == '0) ? (IW+1)'(1) : {1'b0, len};
   assign rem     = pos % divisor;

   always_comb begin
      if (len == '0) begin
         idx_next = idx;
      end else if (sum[SW-1]) begin
         idx_next = under[IW-1:0];
      end else begin
         idx_next = rem[IW-1:0];
      end
   end
endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit
   import addr_step_pkg::*;
#(
   parameter int AW   = 32,
   parameter int OFSW = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [2:0]      mode,
   input  logic [AW-1:0]   base,
   input  logic [AW-1:0]   ptr,
   input  logic [OFSW-1:0] ofs,
   output logic            out_valid,
   output logic [AW-1:0]   ea,
   output logic [AW-1:0]   wb_val,
   output logic            wb_en
);
   localparam int IW = AW / 2;

   if ((AW % 2) != 0) begin : g_bad_aw
      $error("addr_step_unit: AW must be even");
   end
   if (OFSW < 2 || OFSW > IW) begin : g_bad_ofsw
      $error("addr_step_unit: OFSW out of range");
   end

   logic [AW-1:0] ofs_ext;
   logic [AW-1:0] lin_sum;
   logic [AW-1:0] idx_addr;
   logic [IW-1:0] idx;
   logic [IW-1:0] hi;
   logic [IW-1:0] ring_next;
   logic [IW-1:0] brev_next;
   logic [AW-1:0] ea_d;
   logic [AW-1:0] wb_d;
   logic          en_d;

   assign ofs_ext  = {{(AW-OFSW){ofs[OFSW-1]}}, ofs};
   assign lin_sum  = base + ofs_ext;
   assign idx      = ptr[IW-1:0];
   assign hi       = ptr[AW-1:IW];
   assign idx_addr = base + {{(AW-IW){1'b0}}, idx};

   ring_stepper #(.IW(IW), .OFSW(OFSW)) i_ring (
      .idx(idx), .len(hi), .ofs(ofs), .idx_next(ring_next)
   );

   brev_stepper #(.IW(IW)) i_brev (
      .idx(idx), .step(hi), .idx_next(brev_next)
   );

   always_comb begin
      ea_d = lin_sum;
      wb_d = lin_sum;
      en_d = 1'b0;
      case (mode)
         AM_PRE: begin
            en_d = 1'b1;
         end
         AM_POST: begin
            ea_d = base;
            en_d = 1'b1;
         end
         AM_RING: begin
            ea_d = idx_addr;
            wb_d = {hi, ring_next};
            en_d = 1'b1;
         end
         AM_BREV: begin
            ea_d = idx_addr;
            wb_d = {hi, brev_next};
            en_d = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wb_en     <= 1'b0;
         ea        <= '0;
         wb_val    <= '0;
      end else begin
         out_valid <= in_valid;
         wb_en     <= in_valid & en_d;
         if (in_valid) begin
            ea     <= ea_d;
            wb_val <= wb_d;
         end
      end
   end

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));

   // R2
   wb_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> out_valid);

   // R4
   disp_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == AM_DISP) |=> !wb_en);

   // R6
   post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == AM_POST) |=> (ea == $past(base)));

   // R7
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode == AM_RING || mode == AM_BREV))
      |=> (wb_val[AW-1:IW] == $past(ptr[AW-1:IW])));

   // R7
   ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == AM_RING && ptr[AW-1:IW] != '0 && !ofs[OFSW-1]
       && ptr[IW-1:0] < ptr[AW-1:IW])
      |=> (wb_val[IW-1:0] < $past(ptr[AW-1:IW])));

   // R8
   ring_zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode == AM_RING && ptr[AW-1:IW] == '0)
      |=> (wb_val[IW-1:0] == $past(ptr[IW-1:0])));
endmodule

// File: tb/test_addr_step_unit.sv
module test_addr_step_unit;

   typedef struct packed {
      logic [2:0]  mode;
      logic [31:0] base;
      logic [31:0] ptr;
      logic [9:0]  ofs;
      logic [31:0] ea;
      logic [31:0] wb;
      logic        en;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      // R4 R3
      '{3'd0, 32'h0000_1000, 32'h0, 10'h004, 32'h0000_1004, 32'h0000_1004, 1'b0},
      '{3'd0, 32'h0000_1000, 32'h0, 10'h3FC, 32'h0000_0FFC, 32'h0000_0FFC, 1'b0},
      // R5
      '{3'd1, 32'h0000_2000, 32'h0, 10'h010, 32'h0000_2010, 32'h0000_2010, 1'b1},
      '{3'd1, 32'h0000_2000, 32'h0, 10'h200, 32'h0000_1E00, 32'h0000_1E00, 1'b1},
      // R6
      '{3'd2, 32'h0000_3000, 32'h0, 10'h008, 32'h0000_3000, 32'h0000_3008, 1'b1},
      '{3'd2, 32'h0000_0002, 32'h0, 10'h3FF, 32'h0000_0002, 32'h0000_0001, 1'b1},
      // R7
      '{3'd3, 32'h0000_8000, 32'h0010_0004, 10'h008, 32'h0000_8004, 32'h0010_000C, 1'b1},
      '{3'd3, 32'h0000_8000, 32'h0010_000C, 10'h008, 32'h0000_800C, 32'h0010_0004, 1'b1},
      // R9
      '{3'd3, 32'h0000_8000, 32'h0010_0002, 10'h3FC, 32'h0000_8002, 32'h0010_000E, 1'b1},
      // R8
      '{3'd3, 32'h0000_8000, 32'h0000_0005, 10'h003, 32'h0000_8005, 32'h0000_0005, 1'b1},
      // R7 exact boundary and large offset
      '{3'd3, 32'h0000_8000, 32'h0010_0000, 10'h010, 32'h0000_8000, 32'h0010_0000, 1'b1},
      '{3'd3, 32'h0000_8000, 32'h0010_0004, 10'h1FF, 32'h0000_8004, 32'h0010_0003, 1'b1},
      // R10
      '{3'd4, 32'h0000_9000, 32'h8000_0000, 10'h000, 32'h0000_9000, 32'h8000_8000, 1'b1},
      '{3'd4, 32'h0000_9000, 32'h8000_8000, 10'h000, 32'h0001_1000, 32'h8000_4000, 1'b1},
      '{3'd4, 32'h0000_9000, 32'h8000_C000, 10'h000, 32'h0001_5000, 32'h8000_2000, 1'b1},
      '{3'd4, 32'h0000_9000, 32'h8000_FFFF, 10'h000, 32'h0001_8FFF, 32'h8000_0000, 1'b1},
      '{3'd4, 32'h0000_9000, 32'h0004_0004, 10'h155, 32'h0000_9004, 32'h0004_0002, 1'b1},
      // R11
      '{3'd5, 32'h0000_0100, 32'h0, 10'h005, 32'h0000_0105, 32'h0000_0105, 1'b0},
      '{3'd7, 32'h0000_0100, 32'h0, 10'h3FF, 32'h0000_00FF, 32'h0000_00FF, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic [31:0] base = '0;
   logic [31:0] ptr = '0;
   logic [9:0]  ofs = '0;
   logic        out_valid;
   logic [31:0] ea;
   logic [31:0] wb_val;
   logic        wb_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   addr_step_unit i_addr_step_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .base(base), .ptr(ptr), .ofs(ofs), .out_valid(out_valid),
      .ea(ea), .wb_val(wb_val), .wb_en(wb_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      mode = v.mode; base = v.base; ptr = v.ptr; ofs = v.ofs;
      in_valid = 1'b1;
   endtask

   initial begin
      // R1: during reset
      #3;
      check("R1 out_valid", 32'(out_valid), 32'h0);
      check("R1 wb_en", 32'(wb_en), 32'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ea", ea, 32'h0);
      check("R1 wb_val", wb_val, 32'h0);
      check("R1 out_valid after release", 32'(out_valid), 32'h0);

      for (int k = 0; k < NV; k++) begin
         drive(VECS[k]);
         @(negedge clk);
         check($sformatf("R2 valid vec%0d", k), 32'(out_valid), 32'h1);
         check($sformatf("ea vec%0d mode%0d", k, VECS[k].mode), ea, VECS[k].ea);
         check($sformatf("wb_val vec%0d mode%0d", k, VECS[k].mode), wb_val, VECS[k].wb);
         check($sformatf("wb_en vec%0d mode%0d", k, VECS[k].mode), 32'(wb_en), 32'(VECS[k].en));
         in_valid = 1'b0;
      end

      // R2: gap after a write-back request
      drive(VECS[2]);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 no strobe out_valid", 32'(out_valid), 32'h0);
      check("R2 no strobe wb_en", 32'(wb_en), 32'h0);

      // R2: back-to-back requests
      drive(VECS[6]);
      drive(VECS[12]);
      check("R2 b2b first wb_val", wb_val, VECS[6].wb);
      @(negedge clk);
      check("R2 b2b second wb_val", wb_val, VECS[12].wb);
      in_valid = 1'b0;

      // R1: reset in the middle of a run
      drive(VECS[4]);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid reset wb_en", 32'(wb_en), 32'h0);
      check("R1 mid reset ea", ea, 32'h0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mid reset out_valid", 32'(out_valid), 32'h0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule